// File: doc/BRIEF.md
# Pulse-Interval Frame Decoder

This block sits on the listening side of a pulse-pause link. The sender marks every bit with a short gap in the carrier envelope. The time from one rising edge of the envelope to the next encodes the bit value: a long interval is a 1 and a short interval is a 0. The decoder counts enabled ticks between rising edges of an already synchronized envelope input. It classifies each interval against two tolerance bands and collects valid bits, least significant first, into a frame register.

A frame ends in one of two ways: an interval that falls in neither band arrives, or the line stays quiet past the long-bit band while a frame is active. At that point the frame register is either reported or thrown away. It is reported with a one-clock strobe that carries the data and the bit count, and it is thrown away when it holds too few bits. In both cases the register is then cleared for the next frame. Handling the decoded frame and building any reply belong to the logic downstream.

Top module: `pulse_frame_decoder`

## Requirements
- R1: After reset, frame_valid, frame_data and frame_bits are all 0.
- R2: An interval is the number of cycles with tick_en high strictly between two cycles in which env_in rises (a cycle where env_in is 1 and was 0 in the cycle before). A tick in the rising-edge cycle itself is not counted, and the count restarts at every rising edge.
- R3: An interval of 131 to 169 ticks inclusive decodes as bit value 1.
- R4: An interval of 71 to 109 ticks inclusive decodes as bit value 0.
- R5: Any other interval ends the frame if one is active. If no frame is active, it adds no bit and produces no strobe.
- R6: While a frame is active, the frame ends in the cycle in which the tick count since the last rising edge reaches 170 with no new rising edge. A rising edge that lands exactly at count 170 ends the frame only once.
- R7: When a frame of 5 or more bits ends, frame_valid is high for exactly one clock, in the cycle after the end condition. frame_data bit i holds the i-th bit received, with unused upper bits 0, and frame_bits holds the count. Both outputs keep their values until the next strobe.
- R8: A frame of 4 bits or fewer ends without a strobe, and the frame register is cleared after every frame end, reported or not.
- R9: Bits beyond the 31st in one frame are dropped while the frame stays active. Such a frame reports frame_bits = 31 and the first 31 bits.
- R10: Once 3000 ticks pass without a rising edge, the count stops and holds. The next rising edge is therefore treated as an invalid interval, however long the quiet time was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base enable; one tick per cycle it is high |
| env_in | input | 1 | Synchronized carrier envelope level |
| frame_valid | output | 1 | One-clock strobe marking a reported frame |
| frame_data | output | 31 | Frame bits, first received in bit 0 |
| frame_bits | output | 5 | Number of bits in the reported frame |

## Verification
A frame can be ended in the same cycle by both paths: a rising edge whose interval is invalid, and the quiet-line timeout. The case is provoked by placing the edge exactly 170 ticks after the previous one while a frame is active. It is judged by requiring exactly one strobe, in the cycle predicted from the tick count, with the bits collected so far. The bench also lands edges on each band boundary (70, 71, 109, 110, 130, 131, 169) and gates tick_en at random, so that a design counting cycles instead of ticks shows a wrong strobe or a strobe in the wrong cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Outcome of classifying one edge-to-edge interval
    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_ZERO = 2'd1,
        SYM_ONE  = 2'd2,
        SYM_BAD  = 2'd3
    } sym_e;

endpackage

// File: rtl/pfd_edge_timer.sv
module pfd_edge_timer #(
    parameter int IDLE_TICKS = 3000,
    parameter int CNT_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             env_in,
    output logic             rise,
    output logic [CNT_W-1:0] interval
);

    localparam logic [CNT_W-1:0] STOP_AT = CNT_W'(IDLE_TICKS);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             env_prev;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic rise_w;

    always_comb begin
        st_d          = st_q;
        st_d.env_prev = env_in;
        rise_w        = env_in & ~st_q.env_prev;
        if (rise_w) begin
            st_d.cnt = '0;
        end else if (tick_en && (st_q.cnt < STOP_AT) && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise     = rise_w;
    assign interval = st_q.cnt;

endmodule

// File: rtl/pfd_band_match.sv
module pfd_band_match #(
    parameter int CNT_W  = 12,
    parameter int CENTER = 150,
    parameter int FUZZ   = 20
) (
    input  logic [CNT_W-1:0] interval,
    output logic             hit
);

    localparam logic [CNT_W-1:0] LO = CNT_W'(CENTER - FUZZ);
    localparam logic [CNT_W-1:0] HI = CNT_W'(CENTER + FUZZ);

    // Open band on both sides
    always_comb begin
        hit = (interval > LO) && (interval < HI);
    end

endmodule

// File: rtl/pfd_classifier.sv
module pfd_classifier
    import pfd_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int ZERO_TICKS = 90,
    parameter int ONE_TICKS  = 150,
    parameter int FUZZ_TICKS = 20
) (
    input  logic [CNT_W-1:0] interval,
    output sym_e             sym
);

    localparam int NBANDS = 2;
    localparam int CENTER_TAB [NBANDS] = '{ZERO_TICKS, ONE_TICKS};

    logic [NBANDS-1:0] hit;

    for (genvar g = 0; g < NBANDS; g++) begin : g_band
        pfd_band_match #(
            .CNT_W  (CNT_W),
            .CENTER (CENTER_TAB[g]),
            .FUZZ   (FUZZ_TICKS)
        ) u_band (
            .interval (interval),
            .hit      (hit[g])
        );
    end

    // The long band wins if the bands were ever set to overlap
    always_comb begin
        if (hit[1]) begin
            sym = SYM_ONE;
        end else if (hit[0]) begin
            sym = SYM_ZERO;
        end else begin
            sym = SYM_BAD;
        end
    end

endmodule

// File: rtl/pfd_frame_asm.sv
module pfd_frame_asm
    import pfd_pkg::*;
#(
    parameter int DATA_W    = 31,
    parameter int BITS_W    = 5,
    parameter int CNT_W     = 12,
    parameter int MIN_BITS  = 5,
    parameter int END_TICKS = 170
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  sym_e              sym,
    input  logic [CNT_W-1:0]  interval,
    output logic              frame_valid,
    output logic [DATA_W-1:0] frame_data,
    output logic [BITS_W-1:0] frame_bits
);

    localparam logic [CNT_W-1:0]  END_AT   = CNT_W'(END_TICKS);
    localparam logic [BITS_W-1:0] BITS_CAP = BITS_W'(DATA_W);
    localparam logic [BITS_W-1:0] BITS_MIN = BITS_W'(MIN_BITS);

    typedef struct packed {
        logic              active;
        logic [BITS_W-1:0] bits;
        logic [DATA_W-1:0] data;
        logic              out_valid;
        logic [BITS_W-1:0] out_bits;
        logic [DATA_W-1:0] out_data;
    } asm_t;

    asm_t st_d, st_q;
    logic append_w;
    logic close_w;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        append_w       = 1'b0;
        close_w        = 1'b0;

        // An edge outranks the timeout; both can only close once
        if (rise) begin
            if (sym == SYM_ONE || sym == SYM_ZERO) begin
                append_w = 1'b1;
            end else if (st_q.active) begin
                close_w = 1'b1;
            end
        end else if (st_q.active && (interval >= END_AT)) begin
            close_w = 1'b1;
        end

        if (append_w) begin
            st_d.active = 1'b1;
            if (st_q.bits < BITS_CAP) begin
                st_d.data[st_q.bits] = (sym == SYM_ONE);
                st_d.bits            = st_q.bits + 1'b1;
            end
        end

        if (close_w) begin
            if (st_q.bits >= BITS_MIN) begin
                st_d.out_valid = 1'b1;
                st_d.out_data  = st_q.data;
                st_d.out_bits  = st_q.bits;
            end
            st_d.active = 1'b0;
            st_d.bits   = '0;
            st_d.data   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_valid = st_q.out_valid;
    assign frame_data  = st_q.out_data;
    assign frame_bits  = st_q.out_bits;

endmodule

// File: rtl/pulse_frame_decoder.sv
module pulse_frame_decoder
    import pfd_pkg::*;
#(
    parameter  int DATA_W     = 31,
    parameter  int ONE_TICKS  = 150,
    parameter  int ZERO_TICKS = 90,
    parameter  int FUZZ_TICKS = 20,
    parameter  int MIN_BITS   = 5,
    parameter  int IDLE_TICKS = 3000,
    localparam int BITS_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              env_in,
    output logic              frame_valid,
    output logic [DATA_W-1:0] frame_data,
    output logic [BITS_W-1:0] frame_bits
);

    localparam int CNT_W     = $clog2(IDLE_TICKS + 1);
    localparam int END_TICKS = ONE_TICKS + FUZZ_TICKS;

    logic             edge_rise;
    logic [CNT_W-1:0] interval;
    sym_e             sym;

    pfd_edge_timer #(
        .IDLE_TICKS (IDLE_TICKS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .env_in   (env_in),
        .rise     (edge_rise),
        .interval (interval)
    );

    pfd_classifier #(
        .CNT_W      (CNT_W),
        .ZERO_TICKS (ZERO_TICKS),
        .ONE_TICKS  (ONE_TICKS),
        .FUZZ_TICKS (FUZZ_TICKS)
    ) u_class (
        .interval (interval),
        .sym      (sym)
    );

    pfd_frame_asm #(
        .DATA_W    (DATA_W),
        .BITS_W    (BITS_W),
        .CNT_W     (CNT_W),
        .MIN_BITS  (MIN_BITS),
        .END_TICKS (END_TICKS)
    ) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (edge_rise),
        .sym         (sym),
        .interval    (interval),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .frame_bits  (frame_bits)
    );

endmodule

// File: rtl/pulse_frame_decoder_chk.sv
module pulse_frame_decoder_chk #(
    parameter int DATA_W     = 31,
    parameter int BITS_W     = 5,
    parameter int CNT_W      = 12,
    parameter int MIN_BITS   = 5,
    parameter int IDLE_TICKS = 3000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rise,
    input logic [CNT_W-1:0]  cnt,
    input logic              frame_valid,
    input logic [DATA_W-1:0] frame_data,
    input logic [BITS_W-1:0] frame_bits
);

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt == '0)); // R2

    AST_CNT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && (cnt >= CNT_W'(IDLE_TICKS))) |=> $stable(cnt)); // R10

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R7

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(frame_data) && $stable(frame_bits))); // R7

    AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_bits >= BITS_W'(MIN_BITS))); // R8

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ((frame_data >> frame_bits) == '0)); // R9

endmodule

bind pulse_frame_decoder pulse_frame_decoder_chk #(
    .DATA_W     (DATA_W),
    .BITS_W     (BITS_W),
    .CNT_W      (CNT_W),
    .MIN_BITS   (MIN_BITS),
    .IDLE_TICKS (IDLE_TICKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (edge_rise),
    .cnt         (interval),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .frame_bits  (frame_bits)
);

// File: tb/pulse_frame_decoder_test.sv
module pulse_frame_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        env_in = 1'b0;
    logic        frame_valid;
    logic [30:0] frame_data;
    logic [4:0]  frame_bits;

    int checks = 0;
    int errors = 0;
    int cyc_no = 0;
    int obs = 0;
    int tsince = 0;
    logic env_prev = 1'b0;
    logic [30:0] last_d = '0;
    int last_b = 0;

    // requirement model
    logic        m_active = 1'b0;
    int          m_bits = 0;
    logic [30:0] m_data = '0;
    logic [30:0] exp_d[$];
    int          exp_b[$];
    int          exp_c[$];

    pulse_frame_decoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .env_in      (env_in),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .frame_bits  (frame_bits)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d expected finish earlier", cyc_no);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int classify(int n);
        if (n > 130 && n < 170) return 1;
        if (n > 70 && n < 110) return 0;
        return -1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_end();
        if (m_bits >= 5) begin
            exp_d.push_back(m_data);
            exp_b.push_back(m_bits);
            exp_c.push_back(cyc_no);
        end
        m_bits   = 0;
        m_data   = '0;
        m_active = 1'b0;
    endtask

    task automatic step(input logic e, input logic te);
        int   n;
        int   c;
        logic isedge;
        n      = tsince;
        isedge = e && !env_prev;
        if (isedge) begin
            c = classify(n);
            if (c >= 0) begin
                m_active = 1'b1;
                if (m_bits < 31) begin
                    m_data[m_bits] = c[0];
                    m_bits++;
                end
            end else if (m_active) begin
                model_end();
            end
        end else if (m_active && n >= 170) begin
            model_end();
        end
        env_in  = e;
        tick_en = te;
        @(posedge clk);
        #1;
        if (isedge) tsince = 0;
        else if (te && tsince < 3000) tsince++;
        env_prev = e;
        if (frame_valid) begin
            obs++;
            last_d = frame_data;
            last_b = frame_bits;
            if (exp_b.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe bits", frame_bits, 0);
            end else begin
                chk(frame_data === exp_d[0], "R7 frame data", frame_data, exp_d[0]);
                chk(frame_bits == exp_b[0], "R7 frame bits", frame_bits, exp_b[0]);
                chk(cyc_no == exp_c[0], "R6 strobe cycle", cyc_no, exp_c[0]);
                void'(exp_d.pop_front());
                void'(exp_b.pop_front());
                void'(exp_c.pop_front());
            end
        end
        if (exp_c.size() > 0 && exp_c[0] <= cyc_no) begin
            chk(1'b0, "R7 missing strobe cycle", cyc_no, exp_c[0]);
            void'(exp_d.pop_front());
            void'(exp_b.pop_front());
            void'(exp_c.pop_front());
        end
        cyc_no++;
    endtask

    // n ticks after the previous edge, then a rising edge
    task automatic gap(int n, bit rnd);
        int   t = 0;
        int   c = 0;
        logic te;
        while (t < n) begin
            te = rnd ? (($urandom % 8) != 0) : 1'b1;
            step((c == 0) ? env_prev : 1'b0, te);
            if (te) t++;
            c++;
        end
        step(1'b1, 1'b1);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1);
    endtask

    task automatic send_frame(int n, logic [63:0] pat, bit rnd);
        int iv;
        step(1'b1, 1'b1);
        for (int i = 0; i < n; i++) begin
            if (pat[i]) iv = rnd ? 131 + int'($urandom % 39) : 150;
            else        iv = rnd ? 71 + int'($urandom % 39) : 90;
            gap(iv, rnd);
        end
        idle(200);
    endtask

    int mark;
    int bad_tab [6] = '{50, 110, 120, 130, 170, 180};

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        chk(frame_valid == 1'b0, "R1 valid after reset", frame_valid, 0);
        chk(frame_data == '0, "R1 data after reset", frame_data, 0);
        chk(frame_bits == '0, "R1 bits after reset", frame_bits, 0);
        idle(250);

        // nominal mixed pattern, LSB first
        mark = obs;
        send_frame(8, 64'hA5, 1'b0);
        chk(obs - mark == 1, "R3 strobe count", obs - mark, 1);
        chk(last_d == 31'hA5, "R4 data A5", last_d, 32'hA5);

        // band edges inside, then an edge at exactly 170
        step(1'b1, 1'b1);
        gap(131, 0); gap(71, 0); gap(169, 0); gap(109, 0); gap(150, 0);
        mark = obs;
        gap(170, 0);
        chk(obs - mark == 1, "R6 single close at 170", obs - mark, 1);
        chk(last_d == 31'h15, "R3 boundary data", last_d, 32'h15);
        chk(last_b == 5, "R4 boundary bits", last_b, 5);
        idle(200);

        // invalid 130 closes, 110 ignored while idle, 70 closes
        step(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) gap(150, 0);
        mark = obs;
        gap(130, 0);
        chk(obs - mark == 1, "R5 close on 130", obs - mark, 1);
        chk(last_d == 31'h1F, "R5 data before 130", last_d, 32'h1F);
        gap(110, 0);
        for (int i = 0; i < 5; i++) gap(90, 0);
        mark = obs;
        gap(70, 0);
        chk(obs - mark == 1, "R5 close on 70", obs - mark, 1);
        chk(last_b == 5, "R5 110 ignored bits", last_b, 5);
        chk(last_d == 31'h0, "R5 zero data", last_d, 0);
        idle(200);

        // short frames
        mark = obs;
        send_frame(4, 64'hF, 1'b0);
        chk(obs - mark == 0, "R8 four bits dropped", obs - mark, 0);
        send_frame(5, 64'h1B, 1'b0);
        chk(obs - mark == 1, "R8 five bits reported", obs - mark, 1);
        chk(last_d == 31'h1B, "R8 five bit data", last_d, 32'h1B);

        // overlong frame then a clean one
        send_frame(35, {64{1'b1}}, 1'b0);
        chk(last_b == 31, "R9 bit count capped", last_b, 31);
        chk(last_d == 31'h7FFF_FFFF, "R9 first bits kept", last_d, 32'h7FFF_FFFF);
        send_frame(5, 64'h0, 1'b0);
        chk(last_d == 31'h0, "R8 register cleared", last_d, 0);
        chk(last_b == 5, "R8 cleared count", last_b, 5);

        // long quiet: a wrapping count would read 150 here
        idle(4096 + 150 - 200);
        step(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) gap(150, 0);
        idle(200);
        chk(last_b == 5, "R10 edge after idle ignored", last_b, 5);
        chk(last_d == 31'h1F, "R10 data", last_d, 32'h1F);

        // gated ticks
        send_frame(6, 64'h2D, 1'b1);
        chk(last_b == 6, "R2 gated tick count", last_b, 6);
        chk(last_d == 31'h2D, "R2 gated data", last_d, 32'h2D);

        // random frames with occasional invalid intervals
        for (int f = 0; f < 25; f++) begin
            int len;
            len = 1 + int'($urandom % 36);
            step(1'b1, 1'b1);
            for (int i = 0; i < len; i++) begin
                if (($urandom % 12) == 0) gap(bad_tab[$urandom % 6], 1'b1);
                else if ($urandom % 2) gap(131 + int'($urandom % 39), 1'b1);
                else gap(71 + int'($urandom % 39), 1'b1);
            end
            idle(200 + int'($urandom % 100));
        end

        chk(exp_b.size() == 0, "R7 all frames reported", exp_b.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule